// File: doc/BRIEF.md
# Stereo DC-Removal High-Pass Filter

This block takes a stereo stream of signed 24-bit audio samples and strips any constant offset from each channel with a one-pole, one-zero recursive high-pass section. The zero lies exactly at DC and the pole lies just inside the unit circle at 0.9995. The corner frequency is therefore a fixed fraction of the sample rate and follows it whatever that rate is. Left and right samples share one input port, one strobe and one arithmetic datapath. A one-bit tag tells the channels apart, and each channel keeps its own previous input and previous output.

Each accepted sample produces exactly one filtered sample two clock cycles later, with the same tag. Samples may arrive on every cycle in any order of channels, including runs of one channel on consecutive cycles. The recursion runs in fixed point. The feedback state carries guard bits below the output LSB, the feedback product is truncated toward zero so that small residues die out, and the result is clamped to the signed 24-bit range so that it never wraps.

Top module: `dc_blocker`

## Requirements
- R1: For every cycle in which `in_valid` is high, `out_valid` is high exactly two clock cycles later and `out_chan` equals the tag given with that input. `out_valid` is low in every other cycle.
- R2: With input x, previous input p and stored state s (a signed 32-bit value holding 8 fractional bits), the new state is v = (x - p)*256 + trunc0(8384414*s / 2^23), where trunc0 rounds toward zero and 8384414 is the pole 0.9995 in 23 fractional bits. The new state is v clamped to [-2^31, 2^31-1], and the output sample is floor(state / 256).
- R3: Tag 0 is the left channel and tag 1 is the right channel. Each channel's previous input and state change only on that channel's own samples, so samples of one channel never alter the outputs of the other.
- R4: A constant positive input of 1000000, applied to a freshly reset channel, first yields 1000000 and then decays until the output reaches 0.
- R5: When v is above the top of the range, the output is 8388607. When v is below the bottom of the range, the output is -8388608. A full-scale input swing therefore saturates instead of wrapping.
- R6: Synchronous active-high reset clears both channels' previous input and state to zero and drives `out_valid`, `out_chan` and `out_sample` to zero. The first sample after reset therefore comes out unchanged.
- R7: Values on `in_chan` and `in_sample` while `in_valid` is low produce no output and leave both channels' state untouched.
- R8: Samples of the same channel on consecutive cycles each use the state left by the sample just before them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 1 | Input channel tag, 0 left, 1 right |
| in_sample | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 1 | Output channel tag |
| out_sample | output | 24 | Signed filtered sample, saturated |

## Verification
An impulse followed by zeros exposes the exact fixed-point recursion: it separates the truncation direction of the feedback and the scale of the guard bits. A long positive DC run on one channel, fed on every cycle, proves that the zero at DC really drives the output to zero, and that state updates arriving back to back are not lost. Alternating left/right ramps with different shapes, plus a run of right-only samples followed by a left sample, show that the two channel states never mix. Full-scale opposite steps show clamping instead of wrap, and idle cycles carrying junk data together with a mid-run reset show which inputs can touch the state.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

  // Default geometry of the filter
  localparam int  DCB_SAMPLE_W = 24;
  localparam int  DCB_CHANNELS = 2;
  localparam int  DCB_GUARD    = 8;
  localparam int  DCB_FRAC     = 23;
  localparam real DCB_POLE     = 0.9995;

  // Convert a real pole value to a rounded fixed-point integer
  function automatic longint pole_to_fixed(real pole, int frac);
    return longint'($rtoi(pole * (2.0 ** frac) + 0.5));
  endfunction

  // Width of a channel index
  function automatic int chan_bits(int nch);
    return (nch > 1) ? $clog2(nch) : 1;
  endfunction

endpackage

// File: rtl/dcb_state_bank.sv
module dcb_state_bank #(
  parameter int NCH = 2,
  parameter int DW  = 24,
  parameter int SW  = 32,
  parameter int CW  = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [CW-1:0]        wr_sel,
  input  logic signed [DW-1:0] wr_x,
  input  logic signed [SW-1:0] wr_s,
  input  logic [CW-1:0]        rd_sel,
  output logic signed [DW-1:0] rd_x,
  output logic signed [SW-1:0] rd_s
);

  // Per-channel previous input and recursive state
  logic signed [DW-1:0] x_q [NCH];
  logic signed [SW-1:0] s_q [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NCH; k++) begin
        x_q[k] <= '0;
        s_q[k] <= '0;
      end
    end else if (wr_en) begin
      x_q[wr_sel] <= wr_x;
      s_q[wr_sel] <= wr_s;
    end
  end

  // Asynchronous read port: same-cycle reuse after a write
  assign rd_x = x_q[rd_sel];
  assign rd_s = s_q[rd_sel];

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_chk
      AST_CHANNEL_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == CW'(k)) |=> ($stable(x_q[k]) && $stable(s_q[k])))
        else $error("channel %0d state changed without its own write", k); // R3
      AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (x_q[k] == '0 && s_q[k] == '0))
        else $error("channel %0d state not cleared by reset", k); // R6
    end
  endgenerate

endmodule

// File: rtl/dcb_recursion.sv
module dcb_recursion #(
  parameter int     DW     = 24,
  parameter int     GUARD  = 8,
  parameter int     FRAC   = 23,
  parameter longint POLE_Q = 64'd8384414
) (
  input  logic signed [DW-1:0]       x_new,
  input  logic signed [DW-1:0]       x_old,
  input  logic signed [DW+GUARD-1:0] s_old,
  output logic signed [DW+GUARD-1:0] s_new,
  output logic signed [DW-1:0]       y_out,
  output logic                       clipped
);

  localparam int SW   = DW + GUARD;   // state width
  localparam int CQW  = FRAC + 2;     // coefficient width, signed
  localparam int PW   = CQW + SW;     // product width
  localparam int SUMW = SW + 3;       // headroom for difference plus feedback

  localparam logic signed [CQW-1:0]  POLE_S = CQW'(POLE_Q);
  localparam logic signed [PW-1:0]   BIAS   = PW'((64'sd1 <<< FRAC) - 64'sd1);
  localparam logic signed [SUMW-1:0] SAT_HI = SUMW'((64'sd1 <<< (SW - 1)) - 64'sd1);
  localparam logic signed [SUMW-1:0] SAT_LO = SUMW'(-(64'sd1 <<< (SW - 1)));

  logic signed [DW:0]     diff;
  logic signed [SUMW-1:0] diff_sh;
  logic signed [PW-1:0]   prod;
  logic signed [PW-1:0]   prod_adj;
  logic signed [PW-1:0]   prod_sh;
  logic signed [SUMW-1:0] fb;
  logic signed [SUMW-1:0] sum;

  always_comb begin
    // Zero at DC: first difference, lifted to the guard-bit scale
    diff     = (DW+1)'(x_new) - (DW+1)'(x_old);
    diff_sh  = SUMW'(diff) <<< GUARD;
    // Pole: coefficient times state, truncated toward zero
    prod     = PW'(POLE_S) * PW'(s_old);
    prod_adj = prod + (prod[PW-1] ? BIAS : '0);
    prod_sh  = prod_adj >>> FRAC;
    fb       = SUMW'(prod_sh);
    sum      = diff_sh + fb;
    // Clamp to the signed state range
    clipped  = 1'b1;
    if (sum > SAT_HI) begin
      s_new = SAT_HI[SW-1:0];
    end else if (sum < SAT_LO) begin
      s_new = SAT_LO[SW-1:0];
    end else begin
      s_new   = sum[SW-1:0];
      clipped = 1'b0;
    end
    y_out = s_new[SW-1:GUARD];
  end

endmodule

// File: rtl/dc_blocker.sv
module dc_blocker
  import dcb_pkg::*;
#(
  parameter int  SAMPLE_W = DCB_SAMPLE_W,
  parameter int  CHANNELS = DCB_CHANNELS,
  parameter int  GUARD    = DCB_GUARD,
  parameter int  FRAC     = DCB_FRAC,
  parameter real POLE     = DCB_POLE
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [0:0]                 in_chan,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       out_valid,
  output logic [0:0]                 out_chan,
  output logic signed [SAMPLE_W-1:0] out_sample
);

  localparam int     CW     = chan_bits(CHANNELS);
  localparam int     SW     = SAMPLE_W + GUARD;
  localparam longint POLE_Q = pole_to_fixed(POLE, FRAC);

  // Stage 1: captured input
  logic                       s1_valid;
  logic [CW-1:0]              s1_chan;
  logic signed [SAMPLE_W-1:0] s1_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_chan  <= '0;
      s1_x     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_chan <= CW'(in_chan);
        s1_x    <= in_sample;
      end
    end
  end

  // State read, recursion, state write-back
  logic signed [SAMPLE_W-1:0] st_x;
  logic signed [SW-1:0]       st_s;
  logic signed [SW-1:0]       nx_s;
  logic signed [SAMPLE_W-1:0] nx_y;
  logic                       nx_clip;

  dcb_state_bank #(
    .NCH (CHANNELS),
    .DW  (SAMPLE_W),
    .SW  (SW),
    .CW  (CW)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (s1_valid),
    .wr_sel (s1_chan),
    .wr_x   (s1_x),
    .wr_s   (nx_s),
    .rd_sel (s1_chan),
    .rd_x   (st_x),
    .rd_s   (st_s)
  );

  dcb_recursion #(
    .DW     (SAMPLE_W),
    .GUARD  (GUARD),
    .FRAC   (FRAC),
    .POLE_Q (POLE_Q)
  ) u_rec (
    .x_new   (s1_x),
    .x_old   (st_x),
    .s_old   (st_s),
    .s_new   (nx_s),
    .y_out   (nx_y),
    .clipped (nx_clip)
  );

  // Stage 2: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_chan   <= '0;
      out_sample <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_chan   <= 1'(s1_chan);
        out_sample <= nx_y;
      end
    end
  end

  AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid)
    else $error("accepted sample did not emerge after two cycles"); // R1
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2))
    else $error("output strobe without a matching input"); // R1
  AST_TAG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 (out_chan == $past(in_chan, 2)))
    else $error("output tag differs from input tag"); // R1
  AST_CLIP_AT_RAIL: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && nx_clip) |=> (out_sample == {1'b0, {(SAMPLE_W-1){1'b1}}} ||
                               out_sample == {1'b1, {(SAMPLE_W-1){1'b0}}}))
    else $error("clipped result not at a rail"); // R5

endmodule

// File: tb/dc_blocker_test.sv
module dc_blocker_test;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic [0:0]         in_chan = '0;
  logic signed [23:0] in_sample = '0;
  logic               out_valid;
  logic [0:0]         out_chan;
  logic signed [23:0] out_sample;

  always #4 clk = ~clk;

  dc_blocker uut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_chan    (in_chan),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_chan   (out_chan),
    .out_sample (out_sample)
  );

  int     errors = 0;
  int     checks = 0;
  bit     done   = 0;
  string  cur_req = "R1";
  longint last_out = 0;

  // Reference model state, per channel
  longint mx [2];
  longint ms [2];
  localparam longint POLE_FIX = 64'sd8384414;

  // Expected-output pipeline (slot 1: driven one edge ago, slot 2: two)
  bit     pv1 = 0, pv2 = 0;
  bit     pc1 = 0, pc2 = 0;
  longint pd1 = 0, pd2 = 0;

  function automatic longint model_step(int ch, longint x);
    longint d, fb, v;
    d  = x - mx[ch];
    fb = (POLE_FIX * ms[ch]) / 64'sd8388608;
    v  = d * 256 + fb;
    if (v > 64'sd2147483647)  v = 64'sd2147483647;
    if (v < -64'sd2147483648) v = -64'sd2147483648;
    ms[ch] = v;
    mx[ch] = x;
    return v >>> 8;
  endfunction

  task automatic expect_val(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock: check the output due now, then drive the next input
  task automatic step(input bit v, input bit ch, input longint x);
    @(negedge clk);
    checks++;
    if (pv2) begin
      if (!(out_valid === 1'b1 && out_chan === pc2 && longint'(out_sample) == pd2)) begin
        errors++;
        $display("FAIL %s output: actual valid=%0b chan=%0d data=%0d expected valid=1 chan=%0d data=%0d",
                 cur_req, out_valid, out_chan, out_sample, pc2, pd2);
      end
    end else if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s strobe: actual valid=%0b expected valid=0", cur_req, out_valid);
    end
    if (out_valid === 1'b1) last_out = longint'(out_sample);
    pv2 = pv1; pc2 = pc1; pd2 = pd1;
    pv1 = v;   pc1 = ch;
    if (v) pd1 = model_step(int'(ch), x);
    in_valid  = v;
    in_chan   = ch;
    in_sample = x[23:0];
  endtask

  task automatic flush();
    step(0, 0, 0);
    step(0, 0, 0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    pv1 = 0; pv2 = 0;
    mx[0] = 0; mx[1] = 0; ms[0] = 0; ms[1] = 0;
    for (int i = 0; i < 3; i++) step(0, 0, 0);
    expect_val("R6", "reset out_valid", longint'(out_valid), 0);
    expect_val("R6", "reset out_chan", longint'(out_chan), 0);
    expect_val("R6", "reset out_sample", longint'(out_sample), 0);
    rst = 1'b0;
  endtask

  task automatic t_latency();
    cur_req = "R1";
    step(1, 0, 5000);
    step(0, 0, 0);
    step(0, 0, 0);
    step(1, 1, -7000);
    step(1, 0, 300);
    flush();
    step(0, 0, 0);
  endtask

  task automatic t_impulse();
    cur_req = "R2";
    apply_reset();
    cur_req = "R2";
    step(1, 0, 1048576);
    for (int i = 0; i < 40; i++) step(1, 0, 0);
    flush();
    for (int i = 0; i < 10; i++) step(1, 0, -333);
    for (int i = 0; i < 10; i++) step(1, 0, 0);
    flush();
  endtask

  task automatic t_interleave();
    cur_req = "R3";
    apply_reset();
    cur_req = "R3";
    for (int i = 0; i < 60; i++) begin
      step(1, 0, longint'(i) * 1000);
      step(1, 1, 500000 - longint'(i) * 777);
    end
    for (int i = 0; i < 20; i++) step(1, 1, -2000000);
    step(1, 0, 12345);
    flush();
  endtask

  task automatic t_dc();
    cur_req = "R4";
    apply_reset();
    cur_req = "R4";
    step(1, 0, 1000000);
    flush();
    expect_val("R4", "first DC output", last_out, 1000000);
    cur_req = "R8";
    for (int i = 0; i < 30000; i++) step(1, 0, 1000000);
    flush();
    expect_val("R4", "settled DC output", last_out, 0);
  endtask

  task automatic t_saturate();
    cur_req = "R5";
    apply_reset();
    cur_req = "R5";
    step(1, 1, -8388608);
    flush();
    expect_val("R5", "first full-scale low", last_out, -8388608);
    step(1, 1, 8388607);
    flush();
    expect_val("R5", "upward swing clamps", last_out, 8388607);
    step(1, 1, -8388608);
    flush();
    expect_val("R5", "downward swing clamps", last_out, -8388608);
    for (int i = 0; i < 6; i++) begin
      step(1, 1, (i % 2 == 0) ? 8388607 : -8388608);
    end
    flush();
  endtask

  task automatic t_reset_mid();
    cur_req = "R6";
    for (int i = 0; i < 8; i++) step(1, i % 2, 4000000 - longint'(i) * 9000);
    apply_reset();
    cur_req = "R6";
    step(1, 1, -654321);
    flush();
    expect_val("R6", "first sample after reset", last_out, -654321);
    step(1, 0, 222222);
    flush();
    expect_val("R6", "other channel after reset", last_out, 222222);
  endtask

  task automatic t_ignore();
    cur_req = "R7";
    apply_reset();
    cur_req = "R7";
    step(1, 0, 100000);
    step(1, 1, -50000);
    for (int i = 0; i < 12; i++) step(0, i % 2, 8000000 - longint'(i) * 123457);
    flush();
    step(1, 0, 100000);
    step(1, 1, -50000);
    flush();
  endtask

  initial begin
    mx[0] = 0; mx[1] = 0; ms[0] = 0; ms[1] = 0;
    apply_reset();
    t_latency();
    t_impulse();
    t_interleave();
    t_dc();
    t_saturate();
    t_reset_mid();
    t_ignore();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule